// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers interrupt requests for a small 8-bit processor core and turns them into one vectored request. There are two groups of external pins, a non-maskable pin and six peripheral flags: a timer underflow, an A/D end of conversion, three auto-reload timer events (overflow, compare match, capture edge) and a serial end of transfer. Each peripheral flag and each external pin passes through its own enable input before it joins a vector. Vector 1 serves external group A, vector 2 serves external group B and the serial flag, vector 3 serves the auto-reload timer, and vector 4 serves the timer and the A/D converter.

The core programs the block through a write-only option byte on its data bus. That byte sets the sensing mode for group A, the active edge for group B, and a master enable for all maskable vectors. Edge-triggered requests are held in pending flags until the core pulses the acknowledge line for that vector. Level requests follow the pins directly. A wake output tells a sleeping core that a request is waiting. A non-maskable request is always presented, but it can only wake the core when the master enable is on.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the option byte is zero. The master enable is off, group A uses edge sensing, group B uses the falling edge, `irqReq` is 0 and `wake` is 0.
- R2: The option byte is loaded only when `busWe` is 1, `busAddr` is 0xC8 and `busBitOp` is 0. A write to any other address, or any write with `busBitOp` set, leaves the option byte unchanged.
- R3: Data bits 7 and 3..0 of an option write have no effect.
- R4: Option bit 4 is the master enable. While it is 0, vectors 1 to 4 never produce a request.
- R5: A falling edge on `nmiN` sets a pending flag. That flag drives `irqReq` with `irqVec`=0 whatever the master enable is. A pulse on `ack[0]` clears it.
- R6: `wake` is 1 only when `sleep` is 1, the master enable is 1 and a request is present. A pending non-maskable request does not raise `wake` while the master enable is 0.
- R7: Option bit 6 selects how group A is sensed. With bit 6 at 1 (level), vector 1 requests while any enabled group A pin is low, and nothing is latched. With bit 6 at 0 (edge), a new low on any enabled pin latches a request that stays until an `ack[1]` pulse.
- R8: Option bit 5 selects the active edge of group B: 1 for rising, 0 for falling. The edge latches a vector 2 request until an `ack[2]` pulse.
- R9: Each peripheral flag counts only while its own enable input is 1. The serial flag maps to vector 2, the three auto-reload flags to vector 3, and the timer and A/D flags to vector 4.
- R10: When several requests are present, `irqVec` is the lowest number among them: 0 (non-maskable), then 1, 2, 3, 4.
- R11: All external pins and `nmiN` pass through a two-flop synchroniser. A pulse held for at least three clock cycles is never missed, and an edge latches after at most three rising clock edges.
- R12: If a new edge and the acknowledge for the same vector arrive in the same cycle, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Bus write strobe |
| busBitOp | input | 1 | Marks the write as a single-bit set/clear operation |
| busAddr | input | 8 | Bus address |
| busWdata | input | 8 | Bus write data |
| nmiN | input | 1 | Non-maskable request pin, falling edge active |
| extAPin | input | NA | External group A pins, active low |
| extAEn | input | NA | Per-pin enables for group A |
| extBPin | input | NB | External group B pins, edge selectable |
| extBEn | input | NB | Per-pin enables for group B |
| tmrZero | input | 1 | Timer underflow flag |
| tmrZeroEn | input | 1 | Enable for the timer flag |
| adcDone | input | 1 | A/D end-of-conversion flag |
| adcDoneEn | input | 1 | Enable for the A/D flag |
| arOvf | input | 1 | Auto-reload timer overflow flag |
| arOvfEn | input | 1 | Enable for the overflow flag |
| arCmp | input | 1 | Auto-reload timer compare-match flag |
| arCmpEn | input | 1 | Enable for the compare flag |
| arCap | input | 1 | Auto-reload timer capture-edge flag |
| arCapEn | input | 1 | Enable for the capture flag |
| spiDone | input | 1 | Serial end-of-transfer flag |
| spiDoneEn | input | 1 | Enable for the serial flag |
| ack | input | 5 | Acknowledge pulses; bit n clears the latch of vector n |
| sleep | input | 1 | Core is in STOP or WAIT mode |
| irqReq | output | 1 | A request is presented |
| irqVec | output | 3 | Number of the winning vector, 0 to 4 |
| wake | output | 1 | Wake-up request for the sleeping core |

## Verification
The acknowledge that clears a vector 1 latch can fall in the same cycle as a fresh falling edge on a group A pin. The bench provokes this in two steps. It first lets a pending request settle. It then lowers the pin again and times the `ack[1]` pulse for the cycle in which the synchronised edge is detected, which is the third rising edge after the pin change. The collision is correct if vector 1 is still requested after the acknowledge. A later acknowledge on its own must then clear the request. A second overlap is also checked: a pending non-maskable request together with enabled peripheral flags, where the bench expects vector 0 to win and wake to stay low until the master enable is set.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_VEC = 5;
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam logic [7:0] OPT_ADDR = 8'hC8;
  localparam int LES_BIT = 6;
  localparam int POL_BIT = 5;
  localparam int GEN_BIT = 4;

  localparam int PER_N = 6;
  localparam int PER_TMR = 0;
  localparam int PER_ADC = 1;
  localparam int PER_OVF = 2;
  localparam int PER_CMP = 3;
  localparam int PER_CAP = 4;
  localparam int PER_SPI = 5;

  typedef struct packed {
    logic optLoad;
    logic clrNmi;
    logic clrExtA;
    logic clrExtB;
  } vicStrobe_t;

  typedef struct packed {
    logic levelA;
    logic riseB;
    logic gen;
  } vicOpt_t;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] syncQ,
  output logic [W-1:0] histQ
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '1;
      syncQ  <= '1;
      histQ  <= '1;
    end else begin
      stage1 <= din;
      syncQ  <= stage1;
      histQ  <= syncQ;
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NA = 4,
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  vicStrobe_t         stb,
  input  logic [7:0]         busWdata,
  input  logic               nmiN,
  input  logic [NA-1:0]      extAPin,
  input  logic [NA-1:0]      extAEn,
  input  logic [NB-1:0]      extBPin,
  input  logic [NB-1:0]      extBEn,
  input  logic [PER_N-1:0]   perFlag,
  input  logic [PER_N-1:0]   perEn,
  output vicOpt_t            opt,
  output logic [NUM_VEC-1:0] rawReq
);
  localparam int SW = NA + NB + 1;

  logic [SW-1:0] pinSync, pinHist;
  logic [NA-1:0] aSync, aHist;
  logic [NB-1:0] bSync, bHist;
  logic nmiSync, nmiHist;

  vic_sync #(.W(SW)) uSync (
    .clk(clk), .rstN(rstN),
    .din({nmiN, extBPin, extAPin}),
    .syncQ(pinSync), .histQ(pinHist)
  );

  assign aSync   = pinSync[NA-1:0];
  assign aHist   = pinHist[NA-1:0];
  assign bSync   = pinSync[NA+NB-1:NA];
  assign bHist   = pinHist[NA+NB-1:NA];
  assign nmiSync = pinSync[SW-1];
  assign nmiHist = pinHist[SW-1];

  // group activity now and one cycle earlier
  logic aNow, aPrev, bNow, bPrev;
  assign aNow  = |(~aSync & extAEn);
  assign aPrev = |(~aHist & extAEn);
  assign bNow  = |((opt.riseB ? bSync : ~bSync) & extBEn);
  assign bPrev = |((opt.riseB ? bHist : ~bHist) & extBEn);

  logic edgeA, edgeB, edgeNmi;
  assign edgeA   = aNow & ~aPrev & ~opt.levelA;
  assign edgeB   = bNow & ~bPrev;
  assign edgeNmi = ~nmiSync & nmiHist;

  logic pendNmi, pendA, pendB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opt <= '0;
    end else if (stb.optLoad) begin
      opt.levelA <= busWdata[LES_BIT];
      opt.riseB  <= busWdata[POL_BIT];
      opt.gen    <= busWdata[GEN_BIT];
    end
  end

  // a new edge wins over a same-cycle acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendNmi <= 1'b0;
      pendA   <= 1'b0;
      pendB   <= 1'b0;
    end else begin
      if (edgeNmi)          pendNmi <= 1'b1;
      else if (stb.clrNmi)  pendNmi <= 1'b0;
      if (edgeA)            pendA   <= 1'b1;
      else if (stb.clrExtA) pendA   <= 1'b0;
      if (edgeB)            pendB   <= 1'b1;
      else if (stb.clrExtB) pendB   <= 1'b0;
    end
  end

  logic [PER_N-1:0] perHit;
  assign perHit = perFlag & perEn;

  assign rawReq[0] = pendNmi;
  assign rawReq[1] = opt.gen & (opt.levelA ? aNow : pendA);
  assign rawReq[2] = opt.gen & (pendB | perHit[PER_SPI]);
  assign rawReq[3] = opt.gen & (perHit[PER_OVF] | perHit[PER_CMP] | perHit[PER_CAP]);
  assign rawReq[4] = opt.gen & (perHit[PER_TMR] | perHit[PER_ADC]);
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic               busWe,
  input  logic               busBitOp,
  input  logic [7:0]         busAddr,
  input  logic [NUM_VEC-1:0] ack,
  input  logic [NUM_VEC-1:0] rawReq,
  input  logic               gen,
  input  logic               sleep,
  output vicStrobe_t         stb,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output logic               wake
);
  always_comb begin
    stb.optLoad = busWe & ~busBitOp & (busAddr == OPT_ADDR);
    stb.clrNmi  = ack[0];
    stb.clrExtA = ack[1];
    stb.clrExtB = ack[2];
  end

  // scan from the lowest priority up so the lowest index is left
  always_comb begin
    irqReq = 1'b0;
    irqVec = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (rawReq[i]) begin
        irqReq = 1'b1;
        irqVec = VEC_W'(i);
      end
    end
  end

  assign wake = sleep & gen & (|rawReq);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NA = 4,
  parameter int NB = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic               busBitOp,
  input  logic [7:0]         busAddr,
  input  logic [7:0]         busWdata,
  input  logic               nmiN,
  input  logic [NA-1:0]      extAPin,
  input  logic [NA-1:0]      extAEn,
  input  logic [NB-1:0]      extBPin,
  input  logic [NB-1:0]      extBEn,
  input  logic               tmrZero,
  input  logic               tmrZeroEn,
  input  logic               adcDone,
  input  logic               adcDoneEn,
  input  logic               arOvf,
  input  logic               arOvfEn,
  input  logic               arCmp,
  input  logic               arCmpEn,
  input  logic               arCap,
  input  logic               arCapEn,
  input  logic               spiDone,
  input  logic               spiDoneEn,
  input  logic [NUM_VEC-1:0] ack,
  input  logic               sleep,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output logic               wake
);
  vicStrobe_t stb;
  vicOpt_t opt;
  logic [NUM_VEC-1:0] rawReq;
  logic [PER_N-1:0] perFlag, perEn;
  logic optLes, optPol, optGen;

  always_comb begin
    perFlag = '0;
    perEn   = '0;
    perFlag[PER_TMR] = tmrZero;  perEn[PER_TMR] = tmrZeroEn;
    perFlag[PER_ADC] = adcDone;  perEn[PER_ADC] = adcDoneEn;
    perFlag[PER_OVF] = arOvf;    perEn[PER_OVF] = arOvfEn;
    perFlag[PER_CMP] = arCmp;    perEn[PER_CMP] = arCmpEn;
    perFlag[PER_CAP] = arCap;    perEn[PER_CAP] = arCapEn;
    perFlag[PER_SPI] = spiDone;  perEn[PER_SPI] = spiDoneEn;
  end

  assign optLes = opt.levelA;
  assign optPol = opt.riseB;
  assign optGen = opt.gen;

  vic_datapath #(.NA(NA), .NB(NB)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .nmiN(nmiN), .extAPin(extAPin), .extAEn(extAEn),
    .extBPin(extBPin), .extBEn(extBEn),
    .perFlag(perFlag), .perEn(perEn),
    .opt(opt), .rawReq(rawReq)
  );

  vic_control uCtl (
    .busWe(busWe), .busBitOp(busBitOp), .busAddr(busAddr),
    .ack(ack), .rawReq(rawReq), .gen(optGen), .sleep(sleep),
    .stb(stb), .irqReq(irqReq), .irqVec(irqVec), .wake(wake)
  );
endmodule

// File: rtl/vic_checks.sv
module vic_checks
  import vic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic               busBitOp,
  input logic [7:0]         busAddr,
  input logic               sleep,
  input logic               optLes,
  input logic               optPol,
  input logic               optGen,
  input logic [NUM_VEC-1:0] rawReq,
  input logic               irqReq,
  input logic [VEC_W-1:0]   irqVec,
  input logic               wake
);
  a_r2_bitop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busBitOp |=> $stable({optLes, optPol, optGen}));

  a_r2_other_addr: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busAddr != OPT_ADDR |=> $stable({optLes, optPol, optGen}));

  a_r4_gen_blocks: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !optGen |-> irqVec == '0);

  a_r5_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    rawReq[0] |-> irqReq && irqVec == '0);

  a_r6_wake_needs_gen: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> optGen && sleep && irqReq);

  a_r10_vec_range: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqVec < VEC_W'(NUM_VEC));

  a_r10_no_skip_v1: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && irqVec > VEC_W'(1) |-> !rawReq[1] && !rawReq[0]);

  a_r10_no_skip_v2: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && irqVec > VEC_W'(2) |-> !rawReq[2]);
endmodule

bind vec_irq_ctrl vic_checks uChk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busBitOp(busBitOp),
  .busAddr(busAddr), .sleep(sleep), .optLes(optLes), .optPol(optPol),
  .optGen(optGen), .rawReq(rawReq), .irqReq(irqReq), .irqVec(irqVec),
  .wake(wake)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
  localparam int NA = 4;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busBitOp = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic nmiN = 1'b1;
  logic [NA-1:0] extAPin = '1, extAEn = '0;
  logic [NB-1:0] extBPin = '1, extBEn = '0;
  logic [5:0] flg = '0, en = '0; // {spi,cap,cmp,ovf,adc,tmr}
  logic [4:0] ack = '0;
  logic sleep = 1'b0;
  logic irqReq, wake;
  logic [2:0] irqVec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.NA(NA), .NB(NB)) uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busBitOp(busBitOp),
    .busAddr(busAddr), .busWdata(busWdata), .nmiN(nmiN),
    .extAPin(extAPin), .extAEn(extAEn), .extBPin(extBPin), .extBEn(extBEn),
    .tmrZero(flg[0]), .tmrZeroEn(en[0]), .adcDone(flg[1]), .adcDoneEn(en[1]),
    .arOvf(flg[2]), .arOvfEn(en[2]), .arCmp(flg[3]), .arCmpEn(en[3]),
    .arCap(flg[4]), .arCapEn(en[4]), .spiDone(flg[5]), .spiDoneEn(en[5]),
    .ack(ack), .sleep(sleep), .irqReq(irqReq), .irqVec(irqVec), .wake(wake)
  );

  // {flags[5:0], enables[5:0], gen, expReq, expVec[2:0]}
  localparam logic [16:0] VEC_TBL [9] = '{
    {6'b000001, 6'b000001, 1'b1, 1'b1, 3'd4},
    {6'b000001, 6'b000000, 1'b1, 1'b0, 3'd0},
    {6'b000010, 6'b000010, 1'b1, 1'b1, 3'd4},
    {6'b000101, 6'b000101, 1'b1, 1'b1, 3'd3},
    {6'b101001, 6'b111111, 1'b1, 1'b1, 3'd2},
    {6'b111111, 6'b111111, 1'b0, 1'b0, 3'd0},
    {6'b010000, 6'b010000, 1'b1, 1'b1, 3'd3},
    {6'b010000, 6'b001000, 1'b1, 1'b0, 3'd0},
    {6'b111111, 6'b000010, 1'b1, 1'b1, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic bitop);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d; busBitOp = bitop;
    @(negedge clk);
    busWe = 1'b0; busBitOp = 1'b0;
  endtask

  task automatic pulseAck(input int idx);
    @(negedge clk);
    ack[idx] = 1'b1;
    @(negedge clk);
    ack = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, flags enabled but master enable off
    flg = '1; en = '1; sleep = 1'b1;
    @(negedge clk);
    chk("R1 irqReq after reset", irqReq, 0);
    chk("R1 wake after reset", wake, 0);

    // R2: wrong address and bit operation are ignored
    wr(8'hC9, 8'h10, 1'b0);
    @(negedge clk);
    chk("R2 wrong address", irqReq, 0);
    wr(8'hC8, 8'h10, 1'b1);
    @(negedge clk);
    chk("R2 bit op ignored", irqReq, 0);
    wr(8'hC8, 8'h10, 1'b0);
    @(negedge clk);
    chk("R2 full write takes", irqReq, 1);
    chk("R6 wake with gen and sleep", wake, 1);

    // R3: unused bits set, master enable cleared
    wr(8'hC8, 8'h8F, 1'b0);
    @(negedge clk);
    chk("R3 unused bits no effect", irqReq, 0);
    sleep = 1'b0; flg = '0; en = '0;

    // R9 R10 R4: table walk
    foreach (VEC_TBL[i]) begin
      wr(8'hC8, {3'b000, VEC_TBL[i][4], 4'b0000}, 1'b0);
      flg = VEC_TBL[i][16:11];
      en  = VEC_TBL[i][10:5];
      @(negedge clk);
      chk($sformatf("R9 R4 table %0d req", i), irqReq, int'(VEC_TBL[i][3]));
      if (VEC_TBL[i][3])
        chk($sformatf("R10 table %0d vec", i), irqVec, int'(VEC_TBL[i][2:0]));
    end
    flg = '0; en = '0;

    // R5 R6: NMI with master enable off
    wr(8'hC8, 8'h00, 1'b0);
    sleep = 1'b1;
    @(negedge clk); nmiN = 1'b0;
    repeat (3) @(negedge clk); nmiN = 1'b1;
    settle();
    chk("R5 nmi req gen off", irqReq, 1);
    chk("R5 nmi vec", irqVec, 0);
    chk("R6 no wake nmi gen off", wake, 0);
    wr(8'hC8, 8'h10, 1'b0);
    @(negedge clk);
    chk("R6 wake nmi gen on", wake, 1);
    // R10: nmi beats enabled timer
    flg[0] = 1'b1; en[0] = 1'b1;
    @(negedge clk);
    chk("R10 nmi over timer", irqVec, 0);
    pulseAck(0);
    @(negedge clk);
    chk("R5 ack clears nmi", irqVec, 4);
    flg = '0; en = '0; sleep = 1'b0;
    @(negedge clk);
    chk("R6 no request no wake", wake, 0);

    // R7: group A edge mode latches
    wr(8'hC8, 8'h10, 1'b0);
    extAEn = 4'b0100;
    @(negedge clk); extAPin[2] = 1'b0;
    repeat (3) @(negedge clk); extAPin[2] = 1'b1;
    settle();
    chk("R7 edge latched", irqReq, 1);
    chk("R7 edge vec", irqVec, 1);

    // R12: new edge and acknowledge in the same cycle
    @(negedge clk); extAPin[2] = 1'b0;   // before edge k
    @(negedge clk);                       // after k
    @(negedge clk); ack[1] = 1'b1;        // edge detected at k+2
    @(negedge clk); ack = '0;
    @(negedge clk);
    chk("R12 edge wins over ack", irqReq, 1);
    extAPin[2] = 1'b1;
    settle();
    pulseAck(1);
    @(negedge clk);
    chk("R7 ack clears edge latch", irqReq, 0);

    // R7: level mode follows pin
    wr(8'hC8, 8'h50, 1'b0);
    @(negedge clk); extAPin[2] = 1'b0;
    settle();
    chk("R7 level active", irqVec, 1);
    chk("R7 level req", irqReq, 1);
    extAPin[2] = 1'b1;
    settle();
    chk("R7 level not latched", irqReq, 0);
    // R11: disabled pin does not request
    extAPin[0] = 1'b0;
    settle();
    chk("R11 disabled pin", irqReq, 0);
    extAPin[0] = 1'b1; extAEn = '0;

    // R8 R11: group B falling edge, pulse of three cycles
    wr(8'hC8, 8'h10, 1'b0);
    extBEn = 4'b0001;
    @(negedge clk); extBPin[0] = 1'b0;
    repeat (3) @(negedge clk); extBPin[0] = 1'b1;
    settle();
    chk("R11 three-cycle pulse kept", irqReq, 1);
    chk("R8 falling vec", irqVec, 2);
    pulseAck(2);
    @(negedge clk);
    chk("R8 ack clears", irqReq, 0);

    // R8: rising polarity; the falling edge alone must not fire
    extBEn = '0;
    wr(8'hC8, 8'h30, 1'b0);
    extBPin[1] = 1'b0;
    settle();
    extBEn = 4'b0010;
    settle();
    chk("R8 low level no rise", irqReq, 0);
    extBPin[1] = 1'b1;
    settle();
    chk("R8 rising latched", irqReq, 1);
    chk("R8 rising vec", irqVec, 2);
    pulseAck(2);
    @(negedge clk);
    chk("R8 rising ack clears", irqReq, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule